// File: doc/BRIEF.md
# Sector Bit-Flip Correction Engine

This engine repairs a page that is held in a local byte buffer, once a separate root-finding stage has worked out the error locations for each sector. The page is made of `NSECT` sectors. Each sector takes `SECT_BYTES + ECC_B` consecutive buffer bytes: first its data bytes, then its own check bytes. The host loads the page through a byte write port and starts the engine with a per-sector status word. It reads the corrected page back through a registered byte read port once `done` is high.

After `start`, the engine first scans every stored check byte of the page. If all of them are 0xFF, the page counts as erased and finishes at once with success. Otherwise it visits the sectors in ascending order. For each sector whose status bit is set, it asks the locator for that sector's result: a fail flag, an error count, and up to `CORR_T` 1-based bit positions. It then flips the addressed bits, one per clock. A bad locator result aborts the page and bumps a failure counter. A position that falls outside the sector's span aborts the page with a range flag.

The state machine has six states. `ST_IDLE` moves to `ST_SCAN` on start. `ST_SCAN` returns to `ST_IDLE` on the erased-page exit and goes to `ST_SELECT` on the first non-0xFF byte. `ST_SELECT` goes to `ST_WAIT_LOC` for a flagged sector and to `ST_ADVANCE` for a skipped one. `ST_WAIT_LOC` leaves on a locator answer: to `ST_IDLE` on the failure abort, to `ST_ADVANCE` on a zero count, and to `ST_FLIP` otherwise. `ST_FLIP` loops on itself until the last location, then goes to `ST_ADVANCE`; on the range abort it goes to `ST_IDLE`. `ST_ADVANCE` goes to `ST_IDLE` after the last sector and to `ST_SELECT` for the next one.

Top module: `sect_flip_engine`

## Requirements
- R1: After reset, busy, done, page_ok, page_erased, range_err and loc_req are 0, and corr_bits and fail_total are 0.
- R2: When every one of the NSECT*ECC_B check bytes equals 0xFF, the page finishes with done=1, page_ok=1, page_erased=1 and corr_bits=0. No locator request is made and the buffer is left unchanged.
- R3: Sectors are visited in ascending order. loc_req is raised, with loc_sect=s, only for sectors whose status bit s is 1 (bit 0 is sector 0), and at most once per sector.
- R4: A position p maps to v=p-1, byte v/8 and bit v%8 (bit 0 is the LSB). When the byte is below SECT_BYTES, the engine inverts that bit of buffer address s*SPAN+byte.
- R5: When the byte lies in SECT_BYTES..SPAN-1, the engine inverts the bit in check byte (byte-SECT_BYTES) of that sector, at buffer address s*SPAN+byte.
- R6: A position whose byte is at or beyond SPAN, or a position of 0, ends the page with range_err=1 and page_ok=0. It applies no further flips, keeps the flips already made, and leaves fail_total unchanged.
- R7: A locator answer with loc_fail=1, or with loc_count>CORR_T, ends the page with page_ok=0 and raises fail_total by one. No bit of that sector is touched.
- R8: corr_bits counts the bits the page has flipped, summed over its sectors. It clears at each start and holds while idle.
- R9: ECC_B = ceil((12+SECT_BYTES/512)*CORR_T/8), SPAN = SECT_BYTES+ECC_B, and sector s starts at buffer address s*SPAN.
- R10: Host writes are ignored while busy. host_rdata returns the byte at host_raddr one clock after the address is presented.
- R11: busy and done are never high together. done and the result flags hold until the next start.
- R12: The same position given twice in one sector flips its bit twice, which restores the bit, and adds 2 to corr_bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Buffer byte write strobe (ignored while busy) |
| host_waddr | input | AW | Buffer write address |
| host_wdata | input | 8 | Buffer write byte |
| host_raddr | input | AW | Buffer read address |
| host_rdata | output | 8 | Registered buffer read byte |
| start | input | 1 | Begin processing the page (ignored while busy) |
| sect_flags | input | NSECT | Per-sector "needs correction" status, bit s = sector s |
| loc_req | output | 1 | Request for the locator result of loc_sect |
| loc_sect | output | SW | Sector being requested |
| loc_valid | input | 1 | Locator result is present |
| loc_fail | input | 1 | Locator reports the sector uncorrectable |
| loc_count | input | CNT_W | Number of valid positions |
| loc_pos | input | CORR_T*POS_W | Packed 1-based bit positions, slot k at bits k*POS_W |
| busy | output | 1 | Engine is processing a page |
| done | output | 1 | Page finished; results are valid |
| page_ok | output | 1 | Page finished successfully |
| page_erased | output | 1 | Page was recognised as erased |
| range_err | output | 1 | An out-of-range position aborted the page |
| corr_bits | output | TOT_W | Bits flipped in the current page |
| fail_total | output | FAIL_W | Locator failures seen since reset |

## Verification
Some properties are checked on every clock. Each engine write lands inside the current sector's span. No engine write happens once the range flag is up. busy and done are never high together, and done holds until the next start. corr_bits stays within the page maximum and is stable while idle. fail_total only ever steps by one. Engine and host writes never meet at the buffer. Other behaviour can only be shown by the bench's pages: the bit mapping into data and check bytes, the erased-page exit, the skipping and ordering of sectors, keeping earlier flips after an abort, and duplicate positions cancelling out.

// File: rtl/fce_pkg.sv
package fce_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_SELECT,
        ST_WAIT_LOC,
        ST_FLIP,
        ST_ADVANCE
    } fce_state_t;

    // check bytes per sector: field degree grows with the sector size
    function automatic int unsigned ecc_bytes_per_sector(input int unsigned sect_bytes,
                                                         input int unsigned corr_t);
        int unsigned m;
        m = 12 + sect_bytes / 512;
        return (m * corr_t + 7) / 8;
    endfunction

endpackage

// File: rtl/fce_loc_decode.sv
module fce_loc_decode #(
    parameter  int unsigned POS_W = 14,
    parameter  int unsigned SPAN  = 519,
    localparam int unsigned OFF_W = $clog2(SPAN)
) (
    input  logic [POS_W-1:0] pos,
    output logic [OFF_W-1:0] byte_off,
    output logic [2:0]       bit_sel,
    output logic             legal
);
    localparam int unsigned BW = POS_W - 3;
    localparam logic [BW-1:0] SPAN_LIM = BW'(SPAN);

    logic [POS_W-1:0] zero_based;
    logic [BW-1:0]    byte_full;

    always_comb begin
        zero_based = pos - POS_W'(1);
        byte_full  = zero_based[POS_W-1:3];
        bit_sel    = zero_based[2:0];
        byte_off   = byte_full[OFF_W-1:0];
        legal      = (pos != '0) && (byte_full < SPAN_LIM);
    end
endmodule

// File: rtl/fce_buffer.sv
module fce_buffer #(
    parameter  int unsigned DEPTH = 1038,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] e_addr,
    input  logic          e_we,
    input  logic [7:0]    e_wdata,
    output logic [7:0]    e_rdata,
    input  logic          h_we,
    input  logic [AW-1:0] h_waddr,
    input  logic [7:0]    h_wdata,
    input  logic [AW-1:0] h_raddr,
    output logic [7:0]    h_rdata
);
    logic [7:0] mem [DEPTH];

    assign e_rdata = mem[e_addr];

    always_ff @(posedge clk) begin
        if (e_we) begin
            mem[e_addr] <= e_wdata;
        end else if (h_we) begin
            mem[h_waddr] <= h_wdata;
        end
        h_rdata <= mem[h_raddr];
    end

    // R10
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(e_we && h_we));
endmodule

// File: rtl/fce_ctrl.sv
module fce_ctrl
    import fce_pkg::*;
#(
    parameter  int unsigned SECT_BYTES = 512,
    parameter  int unsigned CORR_T     = 4,
    parameter  int unsigned NSECT      = 2,
    parameter  int unsigned FAIL_W     = 8,
    localparam int unsigned ECC_B  = ecc_bytes_per_sector(SECT_BYTES, CORR_T),
    localparam int unsigned SPAN   = SECT_BYTES + ECC_B,
    localparam int unsigned DEPTH  = NSECT * SPAN,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned POS_W  = $clog2(SPAN * 8) + 1,
    localparam int unsigned CNT_W  = $clog2(CORR_T + 1),
    localparam int unsigned SW     = (NSECT > 1) ? $clog2(NSECT) : 1,
    localparam int unsigned TOT_W  = $clog2(NSECT * CORR_T + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NSECT-1:0]        sect_flags,
    output logic                    loc_req,
    output logic [SW-1:0]           loc_sect,
    input  logic                    loc_valid,
    input  logic                    loc_fail,
    input  logic [CNT_W-1:0]        loc_count,
    input  logic [CORR_T*POS_W-1:0] loc_pos,
    output logic [AW-1:0]           e_addr,
    output logic                    e_we,
    output logic [7:0]              e_wdata,
    input  logic [7:0]              e_rdata,
    output logic                    busy,
    output logic                    done,
    output logic                    page_ok,
    output logic                    page_erased,
    output logic                    range_err,
    output logic [TOT_W-1:0]        corr_bits,
    output logic [FAIL_W-1:0]       fail_total
);
    localparam int unsigned OFF_W = $clog2(SPAN);
    localparam int unsigned IW    = (CORR_T > 1) ? $clog2(CORR_T) : 1;
    localparam int unsigned EW    = (ECC_B > 1) ? $clog2(ECC_B) : 1;
    localparam logic [CNT_W-1:0] T_LIM = CNT_W'(CORR_T);

    fce_state_t state_q, state_d;

    // page events, raised by the transition logic
    logic ev_erased, ev_locfail, ev_range, ev_clean;

    logic [SW-1:0]     sect_q;
    logic [AW-1:0]     base_q;
    logic [NSECT-1:0]  flags_q;
    logic [SW-1:0]     scan_sect_q;
    logic [EW-1:0]     scan_off_q;
    logic [AW-1:0]     scan_addr_q;
    logic [POS_W-1:0]  pos_q [CORR_T];
    logic [CNT_W-1:0]  n_q;
    logic [IW-1:0]     idx_q;
    logic [TOT_W-1:0]  corr_q;
    logic [FAIL_W-1:0] fail_q;
    logic              done_q, ok_q, erased_q, range_q;

    logic [OFF_W-1:0]  dec_off [CORR_T];
    logic [2:0]        dec_bit [CORR_T];
    logic              dec_ok  [CORR_T];
    logic [OFF_W-1:0]  sel_off;
    logic [2:0]        sel_bit;
    logic              sel_ok;

    logic scan_last, sect_last, flip_last, loc_bad;

    // one position decoder per location slot
    for (genvar g = 0; g < CORR_T; g++) begin : g_dec
        fce_loc_decode #(
            .POS_W (POS_W),
            .SPAN  (SPAN)
        ) u_dec (
            .pos      (pos_q[g]),
            .byte_off (dec_off[g]),
            .bit_sel  (dec_bit[g]),
            .legal    (dec_ok[g])
        );
    end

    always_comb begin
        sel_off   = dec_off[idx_q];
        sel_bit   = dec_bit[idx_q];
        sel_ok    = dec_ok[idx_q];
        scan_last = (scan_sect_q == SW'(NSECT - 1)) && (scan_off_q == EW'(ECC_B - 1));
        sect_last = (sect_q == SW'(NSECT - 1));
        flip_last = (CNT_W'(idx_q) == n_q - CNT_W'(1));
        loc_bad   = loc_fail || (loc_count > T_LIM);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions and page events
    always_comb begin
        state_d    = state_q;
        ev_erased  = 1'b0;
        ev_locfail = 1'b0;
        ev_range   = 1'b0;
        ev_clean   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (e_rdata != 8'hFF) begin
                    state_d = ST_SELECT;
                end else if (scan_last) begin
                    state_d   = ST_IDLE;
                    ev_erased = 1'b1;
                end
            end
            ST_SELECT: begin
                state_d = flags_q[0] ? ST_WAIT_LOC : ST_ADVANCE;
            end
            ST_WAIT_LOC: begin
                if (loc_valid) begin
                    if (loc_bad) begin
                        state_d    = ST_IDLE;
                        ev_locfail = 1'b1;
                    end else if (loc_count == '0) begin
                        state_d = ST_ADVANCE;
                    end else begin
                        state_d = ST_FLIP;
                    end
                end
            end
            ST_FLIP: begin
                if (!sel_ok) begin
                    state_d  = ST_IDLE;
                    ev_range = 1'b1;
                end else if (flip_last) begin
                    state_d = ST_ADVANCE;
                end
            end
            ST_ADVANCE: begin
                if (sect_last) begin
                    state_d  = ST_IDLE;
                    ev_clean = 1'b1;
                end else begin
                    state_d = ST_SELECT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        loc_req  = (state_q == ST_WAIT_LOC);
        loc_sect = sect_q;
        e_we     = 1'b0;
        e_addr   = '0;
        unique case (state_q)
            ST_SCAN: e_addr = scan_addr_q;
            ST_FLIP: begin
                e_addr = base_q + AW'(sel_off);
                e_we   = sel_ok;
            end
            default: e_addr = '0;
        endcase
        e_wdata     = e_rdata ^ (8'd1 << sel_bit);
        done        = done_q;
        page_ok     = ok_q;
        page_erased = erased_q;
        range_err   = range_q;
        corr_bits   = corr_q;
        fail_total  = fail_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sect_q      <= '0;
            base_q      <= '0;
            flags_q     <= '0;
            scan_sect_q <= '0;
            scan_off_q  <= '0;
            scan_addr_q <= '0;
            n_q         <= '0;
            idx_q       <= '0;
            corr_q      <= '0;
            fail_q      <= '0;
            done_q      <= 1'b0;
            ok_q        <= 1'b0;
            erased_q    <= 1'b0;
            range_q     <= 1'b0;
            for (int k = 0; k < CORR_T; k++) pos_q[k] <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                done_q      <= 1'b0;
                ok_q        <= 1'b0;
                erased_q    <= 1'b0;
                range_q     <= 1'b0;
                corr_q      <= '0;
                sect_q      <= '0;
                base_q      <= '0;
                flags_q     <= sect_flags;
                scan_sect_q <= '0;
                scan_off_q  <= '0;
                scan_addr_q <= AW'(SECT_BYTES);
            end
            if (state_q == ST_SCAN && state_d == ST_SCAN) begin
                if (scan_off_q == EW'(ECC_B - 1)) begin
                    scan_off_q  <= '0;
                    scan_sect_q <= scan_sect_q + SW'(1);
                    scan_addr_q <= scan_addr_q + AW'(SECT_BYTES + 1);
                end else begin
                    scan_off_q  <= scan_off_q + EW'(1);
                    scan_addr_q <= scan_addr_q + AW'(1);
                end
            end
            if (state_q == ST_WAIT_LOC && state_d == ST_FLIP) begin
                n_q   <= loc_count;
                idx_q <= '0;
                for (int k = 0; k < CORR_T; k++) pos_q[k] <= loc_pos[k*POS_W +: POS_W];
            end
            if (state_q == ST_FLIP && sel_ok) begin
                corr_q <= corr_q + TOT_W'(1);
                idx_q  <= idx_q + IW'(1);
            end
            if (state_q == ST_ADVANCE && !sect_last) begin
                sect_q  <= sect_q + SW'(1);
                base_q  <= base_q + AW'(SPAN);
                flags_q <= flags_q >> 1;
            end
            if (ev_erased) begin
                done_q   <= 1'b1;
                ok_q     <= 1'b1;
                erased_q <= 1'b1;
            end
            if (ev_locfail) begin
                done_q <= 1'b1;
                fail_q <= fail_q + FAIL_W'(1);
            end
            if (ev_range) begin
                done_q  <= 1'b1;
                range_q <= 1'b1;
            end
            if (ev_clean) begin
                done_q <= 1'b1;
                ok_q   <= 1'b1;
            end
        end
    end

    // R5
    flip_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_we |-> (({1'b0, e_addr} >= {1'b0, base_q}) &&
                  ({1'b0, e_addr} <  {1'b0, base_q} + (AW+1)'(SPAN))));
    // R6
    range_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> !e_we);
    // R7
    fail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_total != $past(fail_total)) |-> (fail_total == $past(fail_total) + FAIL_W'(1)));
    // R8
    corr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        corr_bits <= TOT_W'(NSECT * CORR_T));
    // R8
    corr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(corr_bits));
    // R11
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

// File: rtl/sect_flip_engine.sv
module sect_flip_engine #(
    parameter  int unsigned SECT_BYTES = 512,
    parameter  int unsigned CORR_T     = 4,
    parameter  int unsigned NSECT      = 2,
    parameter  int unsigned FAIL_W     = 8,
    localparam int unsigned ECC_B  = fce_pkg::ecc_bytes_per_sector(SECT_BYTES, CORR_T),
    localparam int unsigned SPAN   = SECT_BYTES + ECC_B,
    localparam int unsigned DEPTH  = NSECT * SPAN,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned POS_W  = $clog2(SPAN * 8) + 1,
    localparam int unsigned CNT_W  = $clog2(CORR_T + 1),
    localparam int unsigned SW     = (NSECT > 1) ? $clog2(NSECT) : 1,
    localparam int unsigned TOT_W  = $clog2(NSECT * CORR_T + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_we,
    input  logic [AW-1:0]           host_waddr,
    input  logic [7:0]              host_wdata,
    input  logic [AW-1:0]           host_raddr,
    output logic [7:0]              host_rdata,
    input  logic                    start,
    input  logic [NSECT-1:0]        sect_flags,
    output logic                    loc_req,
    output logic [SW-1:0]           loc_sect,
    input  logic                    loc_valid,
    input  logic                    loc_fail,
    input  logic [CNT_W-1:0]        loc_count,
    input  logic [CORR_T*POS_W-1:0] loc_pos,
    output logic                    busy,
    output logic                    done,
    output logic                    page_ok,
    output logic                    page_erased,
    output logic                    range_err,
    output logic [TOT_W-1:0]        corr_bits,
    output logic [FAIL_W-1:0]       fail_total
);
    logic [AW-1:0] e_addr;
    logic          e_we;
    logic [7:0]    e_wdata;
    logic [7:0]    e_rdata;
    logic          h_we;

    assign h_we = host_we && !busy;

    fce_ctrl #(
        .SECT_BYTES (SECT_BYTES),
        .CORR_T     (CORR_T),
        .NSECT      (NSECT),
        .FAIL_W     (FAIL_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .sect_flags  (sect_flags),
        .loc_req     (loc_req),
        .loc_sect    (loc_sect),
        .loc_valid   (loc_valid),
        .loc_fail    (loc_fail),
        .loc_count   (loc_count),
        .loc_pos     (loc_pos),
        .e_addr      (e_addr),
        .e_we        (e_we),
        .e_wdata     (e_wdata),
        .e_rdata     (e_rdata),
        .busy        (busy),
        .done        (done),
        .page_ok     (page_ok),
        .page_erased (page_erased),
        .range_err   (range_err),
        .corr_bits   (corr_bits),
        .fail_total  (fail_total)
    );

    fce_buffer #(
        .DEPTH (DEPTH)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .e_addr  (e_addr),
        .e_we    (e_we),
        .e_wdata (e_wdata),
        .e_rdata (e_rdata),
        .h_we    (h_we),
        .h_waddr (host_waddr),
        .h_wdata (host_wdata),
        .h_raddr (host_raddr),
        .h_rdata (host_rdata)
    );
endmodule

// File: tb/sect_flip_engine_bench.sv
`timescale 1ns/1ps
module sect_flip_engine_bench;
    localparam int SB    = 512;
    localparam int T     = 4;
    localparam int NS    = 2;
    localparam int ECCB  = ((12 + SB / 512) * T + 7) / 8;
    localparam int SPAN  = SB + ECCB;
    localparam int DEPTH = NS * SPAN;
    localparam int AW    = $clog2(DEPTH);
    localparam int POS_W = $clog2(SPAN * 8) + 1;
    localparam int CNT_W = $clog2(T + 1);
    localparam int SW    = (NS > 1) ? $clog2(NS) : 1;
    localparam int TOT_W = $clog2(NS * T + 1);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_we = 1'b0;
    logic [AW-1:0]      host_waddr = '0;
    logic [7:0]         host_wdata = '0;
    logic [AW-1:0]      host_raddr = '0;
    logic [7:0]         host_rdata;
    logic               start = 1'b0;
    logic [NS-1:0]      sect_flags = '0;
    logic               loc_req;
    logic [SW-1:0]      loc_sect;
    logic               loc_valid = 1'b0;
    logic               loc_fail = 1'b0;
    logic [CNT_W-1:0]   loc_count = '0;
    logic [T*POS_W-1:0] loc_pos = '0;
    logic               busy, done, page_ok, page_erased, range_err;
    logic [TOT_W-1:0]   corr_bits;
    logic [7:0]         fail_total;

    sect_flip_engine #(.SECT_BYTES(SB), .CORR_T(T), .NSECT(NS), .FAIL_W(8)) u_sect_flip_engine (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .start(start), .sect_flags(sect_flags), .loc_req(loc_req), .loc_sect(loc_sect),
        .loc_valid(loc_valid), .loc_fail(loc_fail), .loc_count(loc_count), .loc_pos(loc_pos),
        .busy(busy), .done(done), .page_ok(page_ok), .page_erased(page_erased),
        .range_err(range_err), .corr_bits(corr_bits), .fail_total(fail_total)
    );

    always #2 clk = ~clk;

    int vectors = 0;
    int misses  = 0;

    logic [7:0] model [DEPTH];
    int  r_count [NS];
    int  r_pos   [NS][T];
    bit  r_fail  [NS];
    int  seen    [NS];
    int  resp_delay = 0;
    int  dly = 0;
    int  nreq = 0;
    int  prev_s = 0;
    bit  order_bad = 0;

    bit  e_ok, e_erased, e_range;
    int  e_corr;
    int  e_failtot = 0;
    int  e_seen [NS];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    // locator stand-in
    initial begin
        forever begin
            @(negedge clk);
            if (loc_valid) begin
                loc_valid = 1'b0;
            end else if (loc_req) begin
                if (dly < resp_delay) begin
                    dly++;
                end else begin
                    int s;
                    dly = 0;
                    s = int'(loc_sect);
                    if (nreq > 0 && s <= prev_s) order_bad = 1'b1;
                    prev_s = s;
                    nreq++;
                    seen[s]++;
                    loc_count = CNT_W'(r_count[s]);
                    loc_fail  = r_fail[s];
                    for (int k = 0; k < T; k++) loc_pos[k*POS_W +: POS_W] = POS_W'(r_pos[s][k]);
                    loc_valid = 1'b1;
                end
            end
        end
    end

    task automatic clear_resp();
        for (int s = 0; s < NS; s++) begin
            r_count[s] = 0;
            r_fail[s]  = 1'b0;
            seen[s]    = 0;
            e_seen[s]  = 0;
            for (int k = 0; k < T; k++) r_pos[s][k] = 0;
        end
        nreq = 0;
        order_bad = 1'b0;
    endtask

    task automatic poke(input int addr, input logic [7:0] data);
        @(negedge clk);
        host_we = 1'b1;
        host_waddr = AW'(addr);
        host_wdata = data;
        model[addr] = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // mode 0: random bytes everywhere; mode 1: check bytes forced to 0xFF
    task automatic load_page(input int mode);
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if (mode == 1 && (i % SPAN) >= SB) b = 8'hFF;
            @(negedge clk);
            host_we = 1'b1;
            host_waddr = AW'(i);
            host_wdata = b;
            model[i] = b;
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // expected outcome from the requirements; updates the model in place
    task automatic predict(input logic [NS-1:0] flags);
        bit all_ff;
        all_ff = 1'b1;
        e_ok = 1'b0; e_erased = 1'b0; e_range = 1'b0; e_corr = 0;
        for (int s = 0; s < NS; s++)
            for (int j = 0; j < ECCB; j++)
                if (model[s*SPAN + SB + j] != 8'hFF) all_ff = 1'b0;
        if (all_ff) begin
            e_ok = 1'b1; e_erased = 1'b1;
            return;
        end
        for (int s = 0; s < NS; s++) begin
            if (!flags[s]) continue;
            e_seen[s] = 1;
            if (r_fail[s] || r_count[s] > T) begin
                e_failtot++;
                return;
            end
            for (int k = 0; k < r_count[s]; k++) begin
                int p, v;
                p = r_pos[s][k];
                v = p - 1;
                if (p == 0 || v / 8 >= SPAN) begin
                    e_range = 1'b1;
                    return;
                end
                model[s*SPAN + v/8] = model[s*SPAN + v/8] ^ (8'd1 << (v % 8));
                e_corr++;
            end
        end
        e_ok = 1'b1;
    endtask

    task automatic run_page(input logic [NS-1:0] flags, input string buf_req, input bit intrude);
        int wait_cyc;
        int bad;
        int first_bad;
        predict(flags);
        @(negedge clk);
        sect_flags = flags;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            chk(busy == 1'b1, "R10", "busy during intrusion", int'(busy), 1);
            host_we = 1'b1;
            host_waddr = AW'(10);
            host_wdata = ~model[10];
            @(negedge clk);
            host_we = 1'b0;
        end
        wait_cyc = 0;
        while (!done && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        chk(done == 1'b1, "R11", "done", int'(done), 1);
        chk(busy == 1'b0, "R11", "busy at done", int'(busy), 0);
        chk(page_ok == e_ok, "R2", "page_ok", int'(page_ok), int'(e_ok));
        chk(page_erased == e_erased, "R2", "page_erased", int'(page_erased), int'(e_erased));
        chk(range_err == e_range, "R6", "range_err", int'(range_err), int'(e_range));
        chk(int'(corr_bits) == e_corr, "R8", "corr_bits", int'(corr_bits), e_corr);
        chk(int'(fail_total) == e_failtot, "R7", "fail_total", int'(fail_total), e_failtot);
        for (int s = 0; s < NS; s++)
            chk(seen[s] == e_seen[s], "R3", "requests for sector", seen[s], e_seen[s]);
        chk(order_bad == 1'b0, "R3", "ascending order", int'(order_bad), 0);
        // results hold while idle
        repeat (3) @(negedge clk);
        chk(done == 1'b1 && int'(corr_bits) == e_corr, "R11", "results held", int'(done), 1);
        // read back the whole buffer through the registered port
        bad = 0;
        first_bad = -1;
        host_raddr = '0;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            if (host_rdata !== model[i]) begin
                if (first_bad < 0) first_bad = i;
                bad++;
            end
            host_raddr = AW'(i + 1);
        end
        chk(bad == 0, buf_req, "buffer byte mismatches", bad, 0);
        if (first_bad >= 0)
            $display("  first mismatch at %0d", first_bad);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1357);
        clear_resp();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && loc_req == 0, "R1", "busy/done/loc_req", int'({busy, done, loc_req}), 0);
        chk(page_ok == 0 && page_erased == 0 && range_err == 0, "R1", "result flags",
            int'({page_ok, page_erased, range_err}), 0);
        chk(corr_bits == 0 && fail_total == 0, "R1", "counters", int'(corr_bits) + int'(fail_total), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 erased page: locator results present but must not be asked for
        clear_resp();
        load_page(1);
        r_count[0] = 2; r_pos[0][0] = 3; r_pos[0][1] = 40;
        r_count[1] = 1; r_pos[1][0] = 7;
        run_page(2'b11, "R2", 1'b0);

        // R4 R5 R9 boundary positions in data and check bytes, with a host write while busy (R10)
        clear_resp();
        load_page(0);
        model[SB] = 8'h00;
        poke(SB, 8'h00);
        resp_delay = 4;
        r_count[0] = 4;
        r_pos[0][0] = 1; r_pos[0][1] = SB*8; r_pos[0][2] = SB*8 + 1; r_pos[0][3] = SPAN*8;
        r_count[1] = 2; r_pos[1][0] = SPAN*8; r_pos[1][1] = 17;
        run_page(2'b11, "R9", 1'b1);
        resp_delay = 0;

        // R12 duplicate position cancels; R3 sector 0 skipped
        clear_resp();
        load_page(0);
        poke(SPAN + SB, 8'h12);
        r_count[0] = 3; r_pos[0][0] = 5; r_pos[0][1] = 6; r_pos[0][2] = 7;
        r_count[1] = 2; r_pos[1][0] = 100; r_pos[1][1] = 100;
        run_page(2'b10, "R12", 1'b0);

        // R6 out-of-range position after earlier flips
        clear_resp();
        load_page(0);
        poke(SB, 8'h00);
        r_count[0] = 1; r_pos[0][0] = 5;
        r_count[1] = 3; r_pos[1][0] = 9; r_pos[1][1] = SPAN*8 + 1; r_pos[1][2] = 3;
        run_page(2'b11, "R6", 1'b0);

        // R6 position zero is illegal
        clear_resp();
        load_page(0);
        poke(SB, 8'h00);
        r_count[0] = 1; r_pos[0][0] = 0;
        run_page(2'b01, "R6", 1'b0);

        // R7 locator failure on sector 1
        clear_resp();
        load_page(0);
        poke(SB, 8'h00);
        r_count[0] = 2; r_pos[0][0] = 11; r_pos[0][1] = 4000;
        r_count[1] = 1; r_pos[1][0] = 22; r_fail[1] = 1'b1;
        run_page(2'b11, "R7", 1'b0);

        // R7 count above capacity
        clear_resp();
        load_page(0);
        poke(SB, 8'h00);
        r_count[0] = T + 1;
        for (int k = 0; k < T; k++) r_pos[0][k] = 8*k + 1;
        run_page(2'b01, "R7", 1'b0);

        // R2 only the very last check byte differs from 0xFF: not erased
        clear_resp();
        load_page(1);
        poke(DEPTH - 1, 8'hFE);
        r_count[0] = 1; r_pos[0][0] = 8;
        run_page(2'b01, "R4", 1'b0);

        // R4 R5 R8 random pages
        for (int it = 0; it < 5; it++) begin
            logic [NS-1:0] fl;
            clear_resp();
            load_page(0);
            poke(SB, 8'($urandom_range(0, 254)));
            fl = NS'($urandom);
            resp_delay = int'($urandom_range(0, 3));
            for (int s = 0; s < NS; s++) begin
                r_count[s] = int'($urandom_range(0, T));
                for (int k = 0; k < T; k++) r_pos[s][k] = int'($urandom_range(1, SPAN*8));
            end
            run_page(fl, "R5", 1'b0);
        end
        resp_delay = 0;

        finish_run();
    end
endmodule